// File: doc/BRIEF.md
# Frame-Parity Periodic Transfer Launcher

This block decides when one host channel puts a periodic (isochronous or interrupt) transfer on the bus. A frame timer produces a start-of-frame tick and a 14-bit running frame number. At high speed the number advances by one each microframe, so bit 0 is the parity. At full speed it advances by eight each frame, with the low three bits held at zero, so bit 3 is the parity. Software arms the channel with a one-bit odd/even request while the channel enable is high. If the request matches the parity of the live frame number, the transfer starts in the current frame. If not, it waits for the next tick and starts in the following frame. Only the current frame and the next one can ever be reached.

A small bus model answers each launch with a completion pulse. Each launch reports the frame number it actually used, so a scheduler can stay in step with the wire. That frame is also remembered, so a second request that would land in the same frame is refused. A combinational parity helper takes a target frame number and says which parity to request. When the target is already in the past, it returns the current parity so the transfer goes out at once.

Top module: `fpl_launcher`

## Requirements
- R1: While reset is high, frame_num, used_frame, sof, launch, done and reject are all zero.
- R2: A one-cycle sof pulse occurs every HS_TICKS clock cycles at high speed and every FS_TICKS at full speed. The first pulse comes that many cycles after reset is released. On each pulse frame_num has advanced by 1 at high speed or by 8 at full speed, wrapping modulo 2^14.
- R3: An accepted arm whose arm_odd equals the current parity launches without waiting for a tick. launch pulses exactly LAUNCH_DLY+1 cycles after the arm cycle. Parity is frame_num bit 0 at high speed and bit 3 at full speed.
- R4: An accepted arm whose arm_odd differs from the current parity is held until the next sof. launch then pulses exactly LAUNCH_DLY+1 cycles after that sof cycle.
- R5: In the cycle launch is high, used_frame shows the frame number of the frame the transfer started in. For an immediate start this is the frame at the arm. For a deferred start it is the frame shown with the releasing sof. Its parity always equals the requested one.
- R6: An arm in the same cycle as sof is judged against the frame number already showing the new value.
- R7: The parity helper compares pick_target with frame_num; at full speed the low three bits of the target are ignored. If the target is the current frame or the next one, pick_ok is 1 and pick_odd is the target's parity.
- R8: If the target minus the current frame, taken as a signed 14-bit value, is negative, pick_asap is 1, pick_ok is 0 and pick_odd is the current parity. A target two or more frames ahead gives pick_ok=0 and pick_asap=0.
- R9: An arm is refused when its landing frame equals the frame of the last launch, or when chan_en is low. Refusal gives a reject pulse in the next cycle and no launch.
- R10: An arm while a request is pending, counting down or in flight is refused with a reject pulse in the next cycle. The earlier request is unaffected.
- R11: Lowering chan_en before a pending request launches cancels it. This includes lowering it in the very cycle of the releasing sof. No launch and no done follow, and the cancelled frame is not recorded as used.
- R12: done pulses for one cycle exactly XFER_CYC+1 cycles after each launch, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_mode | input | 1 | 1: microframe timing, 0: full-frame timing (held static after reset) |
| chan_en | input | 1 | Channel enable; low cancels a request not yet launched |
| arm | input | 1 | One-cycle request to schedule a transfer |
| arm_odd | input | 1 | Requested frame parity (1 = odd) |
| pick_target | input | 14 | Target frame number for the parity helper |
| sof | output | 1 | Start-of-frame tick |
| frame_num | output | 14 | Running frame number |
| launch | output | 1 | Transfer start pulse to the bus |
| done | output | 1 | Completion pulse from the bus model |
| used_frame | output | 14 | Frame the launched transfer used, valid with launch |
| reject | output | 1 | Arm refused |
| pick_odd | output | 1 | Helper: parity to request |
| pick_ok | output | 1 | Helper: target is the current or next frame |
| pick_asap | output | 1 | Helper: target already passed, current parity chosen |

## Verification
Two functions can collide in one cycle: the frame tick can coincide with an arm, or with the enable being dropped on a waiting request. Directed cases place an arm exactly in the sof cycle, requesting the parity of the frame just beginning. The bench then expects the launch to be timed from that arm against the new frame number. Other directed cases drop chan_en in the sof cycle that would release a waiting request, and expect no launch and no done afterwards. A following arm for that same frame must be accepted, which shows the cancelled frame was never recorded as used.

// File: rtl/fpl_pkg.sv
`timescale 1ns/1ps
package fpl_pkg;
    localparam int FN_W = 14;

    typedef logic [FN_W-1:0] fnum_t;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_WAIT,
        CH_DELAY,
        CH_BUSY
    } ch_state_e;

    typedef struct packed {
        logic odd;
        logic in_reach;
        logic asap;
    } pick_t;

    // distance between two adjacent counted units in frame-number space
    function automatic fnum_t fn_step(logic hs);
        return hs ? fnum_t'(1) : fnum_t'(8);
    endfunction

    function automatic logic fn_par(fnum_t fn, logic hs);
        return hs ? fn[0] : fn[3];
    endfunction

    // full-speed numbers carry no microframe bits
    function automatic fnum_t fn_align(fnum_t fn, logic hs);
        return hs ? fn : {fn[FN_W-1:3], 3'b000};
    endfunction
endpackage

// File: rtl/fpl_frame_timer.sv
`timescale 1ns/1ps
module fpl_frame_timer
    import fpl_pkg::*;
#(
    parameter int HS_TICKS = 40,
    parameter int FS_TICKS = 200
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  hs_mode,
    output logic  sof,
    output fnum_t frame_num
);
    localparam int MAXT = (HS_TICKS > FS_TICKS) ? HS_TICKS : FS_TICKS;
    localparam int CW   = $clog2(MAXT);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = hs_mode ? CW'(HS_TICKS - 1) : CW'(FS_TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            sof       <= 1'b0;
            frame_num <= '0;
        end else begin
            sof <= 1'b0;
            if (cnt >= last) begin
                cnt       <= '0;
                sof       <= 1'b1;
                frame_num <= frame_num + fn_step(hs_mode);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r2_sof_advance: assert property (@(posedge clk) disable iff (rst)
        sof |-> frame_num == $past(frame_num) + fn_step(hs_mode));

    a_r2_sof_single: assert property (@(posedge clk) disable iff (rst)
        sof |=> !sof);

    a_r2_number_steady: assert property (@(posedge clk) disable iff (rst)
        !sof |-> frame_num == $past(frame_num));
endmodule

// File: rtl/fpl_parity_pick.sv
`timescale 1ns/1ps
module fpl_parity_pick
    import fpl_pkg::*;
(
    input  logic  hs_mode,
    input  fnum_t cur_fn,
    input  fnum_t target,
    output pick_t pick
);
    fnum_t tgt;
    fnum_t diff;

    always_comb begin
        tgt           = fn_align(target, hs_mode);
        diff          = tgt - cur_fn;
        pick.odd      = fn_par(tgt, hs_mode);
        pick.in_reach = 1'b0;
        pick.asap     = 1'b0;
        if (diff == '0 || diff == fn_step(hs_mode)) begin
            pick.in_reach = 1'b1;
        end else if (diff[FN_W-1]) begin
            pick.asap = 1'b1;
            pick.odd  = fn_par(cur_fn, hs_mode);
        end
    end
endmodule

// File: rtl/fpl_bus_stub.sv
`timescale 1ns/1ps
module fpl_bus_stub #(
    parameter int XFER_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic done
);
    localparam int CW = $clog2(XFER_CYC + 1);

    logic          active;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                active <= 1'b1;
                cnt    <= CW'(XFER_CYC - 1);
            end else if (active) begin
                if (cnt == '0) begin
                    done   <= 1'b1;
                    active <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r12_no_done_at_launch: assert property (@(posedge clk) disable iff (rst)
        launch |-> !done);
endmodule

// File: rtl/fpl_channel.sv
`timescale 1ns/1ps
module fpl_channel
    import fpl_pkg::*;
#(
    parameter int LAUNCH_DLY = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  hs_mode,
    input  logic  sof,
    input  fnum_t cur_fn,
    input  logic  chan_en,
    input  logic  arm,
    input  logic  arm_odd,
    input  logic  done,
    output logic  launch,
    output fnum_t used_frame,
    output logic  reject
);
    localparam int DW = $clog2(LAUNCH_DLY + 1);

    ch_state_e     state;
    logic [DW-1:0] dcnt;
    fnum_t         hold_fn;
    fnum_t         last_fn;
    logic          last_vld;
    logic          req_odd;

    logic  match;
    fnum_t land_fn;
    logic  clash;
    logic  accept;

    always_comb begin
        match   = (arm_odd == fn_par(cur_fn, hs_mode));
        land_fn = match ? cur_fn : cur_fn + fn_step(hs_mode);
        clash   = last_vld && (land_fn == last_fn);
        accept  = arm && chan_en && (state == CH_IDLE) && !clash;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CH_IDLE;
            dcnt       <= '0;
            hold_fn    <= '0;
            last_fn    <= '0;
            last_vld   <= 1'b0;
            req_odd    <= 1'b0;
            launch     <= 1'b0;
            used_frame <= '0;
            reject     <= 1'b0;
        end else begin
            launch <= 1'b0;
            reject <= arm && !accept;
            unique case (state)
                CH_IDLE: begin
                    if (accept) begin
                        req_odd <= arm_odd;
                        if (match) begin
                            state   <= CH_DELAY;
                            dcnt    <= DW'(LAUNCH_DLY - 1);
                            hold_fn <= cur_fn;
                        end else begin
                            state <= CH_WAIT;
                        end
                    end
                end
                CH_WAIT: begin
                    if (!chan_en) begin
                        state <= CH_IDLE;
                    end else if (sof) begin
                        state   <= CH_DELAY;
                        dcnt    <= DW'(LAUNCH_DLY - 1);
                        hold_fn <= cur_fn;
                    end
                end
                CH_DELAY: begin
                    if (!chan_en) begin
                        state <= CH_IDLE;
                    end else if (dcnt == '0) begin
                        launch     <= 1'b1;
                        used_frame <= hold_fn;
                        last_fn    <= hold_fn;
                        last_vld   <= 1'b1;
                        state      <= CH_BUSY;
                    end else begin
                        dcnt <= dcnt - 1'b1;
                    end
                end
                CH_BUSY: begin
                    if (done) state <= CH_IDLE;
                end
                default: state <= CH_IDLE;
            endcase
        end
    end

    // R3, R4: the frame used always carries the requested parity
    a_r5_lands_on_parity: assert property (@(posedge clk) disable iff (rst)
        launch |-> fn_par(used_frame, hs_mode) == req_odd);

    a_r10_busy_refused: assert property (@(posedge clk) disable iff (rst)
        (arm && state != CH_IDLE) |=> reject);

    a_r11_cancel_clean: assert property (@(posedge clk) disable iff (rst)
        (state == CH_WAIT && !chan_en) |=> (state == CH_IDLE && !launch));

    a_r3_launch_single: assert property (@(posedge clk) disable iff (rst)
        launch |=> !launch);
endmodule

// File: rtl/fpl_launcher.sv
`timescale 1ns/1ps
module fpl_launcher
    import fpl_pkg::*;
#(
    parameter int HS_TICKS   = 40,
    parameter int FS_TICKS   = 200,
    parameter int LAUNCH_DLY = 2,
    parameter int XFER_CYC   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hs_mode,
    input  logic        chan_en,
    input  logic        arm,
    input  logic        arm_odd,
    input  logic [13:0] pick_target,
    output logic        sof,
    output logic [13:0] frame_num,
    output logic        launch,
    output logic        done,
    output logic [13:0] used_frame,
    output logic        reject,
    output logic        pick_odd,
    output logic        pick_ok,
    output logic        pick_asap
);
    fnum_t fn_cur;
    fnum_t fn_used;
    pick_t pick;

    fpl_frame_timer #(
        .HS_TICKS (HS_TICKS),
        .FS_TICKS (FS_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .hs_mode   (hs_mode),
        .sof       (sof),
        .frame_num (fn_cur)
    );

    fpl_parity_pick u_pick (
        .hs_mode (hs_mode),
        .cur_fn  (fn_cur),
        .target  (pick_target),
        .pick    (pick)
    );

    fpl_channel #(
        .LAUNCH_DLY (LAUNCH_DLY)
    ) u_chan (
        .clk        (clk),
        .rst        (rst),
        .hs_mode    (hs_mode),
        .sof        (sof),
        .cur_fn     (fn_cur),
        .chan_en    (chan_en),
        .arm        (arm),
        .arm_odd    (arm_odd),
        .done       (done),
        .launch     (launch),
        .used_frame (fn_used),
        .reject     (reject)
    );

    fpl_bus_stub #(
        .XFER_CYC (XFER_CYC)
    ) u_bus (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .done   (done)
    );

    assign frame_num  = fn_cur;
    assign used_frame = fn_used;
    assign pick_odd   = pick.odd;
    assign pick_ok    = pick.in_reach;
    assign pick_asap  = pick.asap;

    a_r8_asap_current: assert property (@(posedge clk) disable iff (rst)
        pick_asap |-> (pick_odd == fn_par(fn_cur, hs_mode) && !pick_ok));

    a_r7_reach_parity: assert property (@(posedge clk) disable iff (rst)
        pick_ok |-> pick_odd == fn_par(fn_align(pick_target, hs_mode), hs_mode));
endmodule

// File: tb/test_fpl_launcher.sv
`timescale 1ns/1ps
module test_fpl_launcher;
    localparam int HS_T = 40;
    localparam int FS_T = 200;
    localparam int DLY  = 2;
    localparam int XF   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs_mode = 1'b0;
    logic        chan_en = 1'b1;
    logic        arm = 1'b0;
    logic        arm_odd = 1'b0;
    logic [13:0] pick_target = '0;
    logic        sof, launch, done, reject, pick_odd, pick_ok, pick_asap;
    logic [13:0] frame_num, used_frame;

    fpl_launcher #(
        .HS_TICKS (HS_T), .FS_TICKS (FS_T), .LAUNCH_DLY (DLY), .XFER_CYC (XF)
    ) i_fpl_launcher (
        .clk (clk), .rst (rst), .hs_mode (hs_mode), .chan_en (chan_en),
        .arm (arm), .arm_odd (arm_odd), .pick_target (pick_target),
        .sof (sof), .frame_num (frame_num), .launch (launch), .done (done),
        .used_frame (used_frame), .reject (reject), .pick_odd (pick_odd),
        .pick_ok (pick_ok), .pick_asap (pick_asap)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    int          n_chk = 0;
    int          n_fail = 0;
    bit          over = 0;
    bit          lu_v = 0;
    logic [13:0] lu_fn = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int per();
        return hs_mode ? HS_T : FS_T;
    endfunction

    function automatic logic [13:0] st();
        return hs_mode ? 14'd1 : 14'd8;
    endfunction

    function automatic logic [13:0] fn_at(input int k);
        return 14'((k / per()) * int'(st()));
    endfunction

    function automatic logic par(input logic [13:0] f);
        return hs_mode ? f[0] : f[3];
    endfunction

    task automatic to_phase(input int ph);
        @(negedge clk);
        while (cyc % per() != ph) @(negedge clk);
    endtask

    task automatic to_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // arm at the next negedge and follow the transfer to its end
    task automatic do_arm(input logic odd);
        int k, L, S;
        logic [13:0] f, land, used;
        bit match, rej;
        @(negedge clk);
        arm = 1'b1; arm_odd = odd;
        k = cyc; f = fn_at(k);
        match = (par(f) == odd);
        land  = match ? f : f + st();
        rej   = !chan_en || (lu_v && land == lu_fn);
        @(negedge clk);
        arm = 1'b0;
        chk(reject == rej, "R9 reject flag", int'(reject), int'(rej));
        if (rej) begin
            bit seen = 0;
            repeat (per()) begin
                @(negedge clk);
                if (launch) seen = 1;
            end
            chk(!seen, "R9 refused arm must not launch", int'(seen), 0);
            return;
        end
        if (match) begin
            L = k + 1 + DLY; used = f;
        end else begin
            S = (k / per() + 1) * per(); L = S + 1 + DLY; used = fn_at(S);
        end
        while (cyc < L + 1 + XF) begin
            @(negedge clk);
            if (cyc == L) begin
                chk(launch === 1'b1, match ? "R3 immediate launch" : "R4 deferred launch",
                    int'(launch), 1);
                chk(used_frame == used, "R5 used frame", int'(used_frame), int'(used));
            end else if (launch) begin
                chk(0, "R3 launch in wrong cycle", cyc, L);
            end
            if (cyc == L + 1 + XF) chk(done === 1'b1, "R12 done timing", int'(done), 1);
            else if (done)         chk(0, "R12 done in wrong cycle", cyc, L + 1 + XF);
        end
        lu_v = 1; lu_fn = used;
    endtask

    task automatic do_reset(input logic hs);
        rst = 1'b1; hs_mode = hs; chan_en = 1'b1; arm = 1'b0;
        repeat (3) @(negedge clk);
        chk(frame_num == 0 && used_frame == 0, "R1 reset numbers", int'(frame_num), 0);
        chk({sof, launch, done, reject} == 4'b0, "R1 reset pulses",
            int'({sof, launch, done, reject}), 0);
        rst = 1'b0;
        lu_v = 0;
    endtask

    task automatic tick_test();
        int s1;
        logic [13:0] f1;
        @(negedge clk);
        while (!sof) @(negedge clk);
        s1 = cyc; f1 = frame_num;
        chk(f1 == fn_at(s1), "R2 frame value at tick", int'(f1), int'(fn_at(s1)));
        @(negedge clk);
        while (!sof) @(negedge clk);
        chk(cyc - s1 == per(), "R2 tick period", cyc - s1, per());
        chk(frame_num - f1 == st(), "R2 frame step", int'(frame_num - f1), int'(st()));
    endtask

    task automatic pick_case(input int off, input logic [2:0] low);
        logic [13:0] f;
        bit e_ok, e_asap;
        logic e_odd;
        f = frame_num;
        pick_target = f + 14'(off * int'(st())) + (hs_mode ? 14'd0 : {11'd0, low});
        #0.2;
        e_ok   = (off == 0 || off == 1);
        e_asap = (off < 0);
        e_odd  = (off == 1) ? !par(f) : (e_ok || e_asap) ? par(f) : pick_odd;
        if (e_asap)
            chk(pick_asap && !pick_ok && pick_odd == e_odd, "R8 past target",
                int'({pick_asap, pick_ok, pick_odd}), int'({1'b1, 1'b0, e_odd}));
        else if (e_ok)
            chk(pick_ok && !pick_asap && pick_odd == e_odd, "R7 reachable target",
                int'({pick_asap, pick_ok, pick_odd}), int'({1'b0, 1'b1, e_odd}));
        else
            chk(!pick_ok && !pick_asap, "R8 far target",
                int'({pick_asap, pick_ok}), 0);
    endtask

    task automatic pick_test();
        to_phase(5);
        pick_case(0, 3'd0);
        pick_case(1, 3'd0);
        pick_case(-1, 3'd0);
        pick_case(-4, 3'd0);
        pick_case(2, 3'd0);
        pick_case(0, 3'd5);
        pick_case(1, 3'd7);
    endtask

    // R10: second arm while the first is counting down
    task automatic busy_test();
        int k, L;
        logic [13:0] f;
        to_phase(2);
        k = cyc; f = fn_at(k);
        arm = 1'b1; arm_odd = par(f);
        @(negedge clk);
        chk(reject == 1'b0, "R10 first arm accepted", int'(reject), 0);
        @(negedge clk);
        arm = 1'b0;
        chk(reject == 1'b1, "R10 second arm refused", int'(reject), 1);
        L = k + 1 + DLY;
        to_cyc(L);
        chk(launch === 1'b1, "R10 first request still launches", int'(launch), 1);
        to_cyc(L + 1 + XF);
        lu_v = 1; lu_fn = f;
    endtask

    task automatic cancel_test(input bit coincide);
        int k, S, stop;
        logic [13:0] f;
        bit seen_l, seen_d;
        to_phase(1);
        k = cyc; f = fn_at(k);
        arm = 1'b1; arm_odd = !par(f);
        @(negedge clk);
        arm = 1'b0;
        chk(reject == 1'b0, "R11 deferred arm accepted", int'(reject), 0);
        S = (k / per() + 1) * per();
        to_cyc(coincide ? S : S - 5);
        chan_en = 1'b0;
        seen_l = 0; seen_d = 0;
        stop = S + DLY + XF + 4;
        while (cyc < stop) begin
            @(negedge clk);
            if (launch) seen_l = 1;
            if (done) seen_d = 1;
        end
        chk(!seen_l, "R11 cancelled request launched", int'(seen_l), 0);
        chk(!seen_d, "R11 cancelled request completed", int'(seen_d), 0);
        chan_en = 1'b1;
        // the cancelled frame is still free: immediate arm in it must be accepted
        do_arm(par(fn_at(cyc + 1)));
    endtask

    // R6: arm driven in the very cycle of the tick
    task automatic sof_arm_test();
        to_phase(per() - 1);
        do_arm(!par(fn_at(cyc + 1)));
        to_phase(per() - 1);
        do_arm(par(fn_at(cyc + 1)));
    endtask

    task automatic random_run(input int n);
        repeat (n) begin
            repeat ($urandom % 45) @(negedge clk);
            do_arm(1'($urandom % 2));
        end
    endtask

    task automatic same_frame_test();
        logic [13:0] f;
        to_phase(3);
        f = fn_at(cyc + 1);
        do_arm(par(f));
        do_arm(par(f));
        do_arm(!par(f));
    endtask

    initial begin
        void'($urandom(32'd4242));
        // full-speed phase
        do_reset(1'b0);
        busy_test();
        tick_test();
        pick_test();
        same_frame_test();
        cancel_test(1'b0);
        cancel_test(1'b1);
        sof_arm_test();
        chan_en = 1'b0;
        do_arm(1'b0);
        chan_en = 1'b1;
        random_run(40);
        // high-speed phase
        do_reset(1'b1);
        tick_test();
        pick_test();
        same_frame_test();
        cancel_test(1'b1);
        sof_arm_test();
        random_run(60);
        if (!over) begin
            over = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!over) begin
            over = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule